// File: doc/BRIEF.md
# Byte Stream Packet Packer with Automatic Commit

The block captures an 8-bit parallel byte stream from an external source through a strobe/ready handshake. It packs the bytes into a ring of fixed-size packet buffers. A buffer that reaches the configured packet size goes to a bulk-IN style output port (valid/ready/last) with no processor involvement. Capture starts again by itself whenever the output side frees a buffer, so a steady stream needs no supervision once `arm` is high.

Lowering `arm` stops capture cleanly. A byte transfer that is under way is allowed to finish. The block then reports idle and throws away the partly filled buffer, which never reaches the output. A buffer-flush request holds the output in a NAK state, clears every buffer, and then releases the output. A zero-length packet can be queued while capture is off. A sticky flag records any byte that a misbehaving source pushed while all buffers were full.

Top module: `pkt_stream_packer`

## Requirements
- R1: A byte is accepted only on a rising clock edge where `rd_strobe` and `src_rdy` are both high. Bytes leave on `out_data` in the same order they were accepted.
- R2: A buffer is committed as soon as it holds exactly PKT_BYTES bytes. It is presented as PKT_BYTES beats, with `out_last` high on the final beat only.
- R3: There are NBUF (default 4) buffers. While all of them are committed and undrained, `rd_strobe` stays low, so no further byte is taken and no stored byte is overwritten.
- R4: While `arm` is high, capture resumes without any other input once the output drains a buffer.
- R5: `overflow` is a sticky flag. It sets when `src_rdy` is high while `rd_strobe` is low, `arm` is high and no buffer is free. That byte is dropped. The flag clears on `rst_n` or during a buffer flush.
- R6: `cap_done` reads 1 except while a byte transfer is outstanding, which is exactly when `rd_strobe` is high.
- R7: When `arm` falls, an outstanding transfer first completes and `cap_done` returns to 1. The partly filled buffer is then discarded and never appears on the output.
- R8: `zlp_req` has effect only when all of these hold: capture is off, the current buffer is empty, and a buffer is free. Its effect is to queue a zero-length packet, presented as one beat with `out_empty`=1, `out_last`=1 and `out_data`=0.
- R9: `fifo_rst` is accepted only while `cap_done`=1. When accepted, `nak_all` is high for exactly the two cycles that follow, and the buffers are cleared while it is high. After `nak_all` is released, `out_valid` is 0. While `nak_all` is high, `out_valid` and `rd_strobe` are low.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold steady.
- R11: After `rst_n`, `rd_strobe`, `out_valid`, `nak_all` and `overflow` are 0 and `cap_done` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Level: capture enabled while high |
| fifo_rst | input | 1 | Request a NAK-guarded clear of all buffers |
| zlp_req | input | 1 | Request a zero-length output packet |
| src_rdy | input | 1 | Source answers the strobe with a byte |
| src_data | input | 8 | Source byte |
| rd_strobe | output | 1 | Read strobe; a transfer is outstanding |
| cap_done | output | 1 | Capture engine idle |
| overflow | output | 1 | Sticky: byte pushed while no buffer free |
| nak_all | output | 1 | Output side held off during flush |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat accepted |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final beat of a packet |
| out_empty | output | 1 | Beat is a zero-length packet marker |

## Verification
The hardest state to reach from the ports is a ring with every buffer committed and capture stalled, with a source that then disregards the stall. The bench reaches it by holding `out_ready` low while a source model answers strobes. Once the strobe has stayed low, it lets that source push a byte against the low strobe. Only then is the output released, so that automatic resumption and the untouched contents of the stalled buffers can be seen. A stop issued while a transfer is outstanding is produced by muting the source until the strobe is high, then dropping `arm` before the source answers.

// File: rtl/psp_pkg.sv
package psp_pkg;

  typedef enum logic [1:0] {CAP_OFF, CAP_WAIT, CAP_XFER, CAP_DROP} cap_state_e;
  typedef enum logic [1:0] {FL_IDLE, FL_NAK, FL_CLR, FL_REL} flush_state_e;

  // next index around a ring of n entries
  function automatic int unsigned ring_inc(int unsigned idx, int unsigned n);
    return (idx + 1 == n) ? 0 : idx + 1;
  endfunction

  // flat storage address of byte c within buffer b
  function automatic int unsigned slot_addr(int unsigned b, int unsigned c, int unsigned pkt);
    return b * pkt + c;
  endfunction

  // c is the position of the last byte of a packet
  function automatic bit is_final(int unsigned c, int unsigned pkt);
    return (c + 1) == pkt;
  endfunction

endpackage

// File: rtl/psp_capture_fsm.sv
module psp_capture_fsm
  import psp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic src_rdy,
  input  logic buf_free,
  input  logic hold,
  output logic rd_strobe,
  output logic byte_take,
  output logic drop,
  output logic cap_done,
  output logic cap_off,
  output logic ovf_evt
);

  cap_state_e st, nx;

  always_comb begin
    nx = st;
    case (st)
      CAP_OFF:  if (arm && !hold) nx = CAP_WAIT;
      CAP_WAIT: if (!arm) nx = CAP_DROP;
                else if (buf_free && !hold) nx = CAP_XFER;
      CAP_XFER: if (src_rdy) nx = arm ? CAP_WAIT : CAP_DROP;
      CAP_DROP: nx = CAP_OFF;
      default:  nx = CAP_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= CAP_OFF;
    else        st <= nx;
  end

  assign rd_strobe = (st == CAP_XFER);
  assign byte_take = rd_strobe && src_rdy;
  assign drop      = (st == CAP_DROP);
  assign cap_done  = !rd_strobe;
  assign cap_off   = (st == CAP_OFF);
  assign ovf_evt   = src_rdy && !rd_strobe && arm && !buf_free;

endmodule

// File: rtl/psp_flush_seq.sv
module psp_flush_seq
  import psp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_rst,
  input  logic cap_done,
  output logic nak,
  output logic clr,
  output logic busy
);

  flush_state_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= FL_IDLE;
    else begin
      case (st)
        FL_IDLE: if (fifo_rst && cap_done) st <= FL_NAK;
        FL_NAK:  st <= FL_CLR;
        FL_CLR:  st <= FL_REL;
        default: st <= FL_IDLE;
      endcase
    end
  end

  assign nak  = (st == FL_NAK) || (st == FL_CLR);
  assign clr  = (st == FL_CLR);
  assign busy = (st != FL_IDLE);

endmodule

// File: rtl/psp_ring_store.sv
module psp_ring_store
  import psp_pkg::*;
#(
  parameter int PKT_BYTES = 512,
  parameter int NBUF      = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       drop,
  input  logic       zlp_go,
  input  logic       clr,
  input  logic       nak,
  input  logic       out_ready,
  output logic       buf_free,
  output logic       wr_empty,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last,
  output logic       out_empty
);

  localparam int BW    = $clog2(NBUF);
  localparam int CW    = $clog2(PKT_BYTES);
  localparam int NW    = $clog2(NBUF + 1);
  localparam int DEPTH = NBUF * PKT_BYTES;
  localparam int AW    = $clog2(DEPTH);

  logic [7:0]      mem [DEPTH];
  logic [BW-1:0]   wr_buf, rd_buf;
  logic [CW-1:0]   wr_cnt, rd_cnt;
  logic [NW-1:0]   n_full;
  logic [NBUF-1:0] zflag;

  logic commit_full, commit, release_buf, out_fire;
  logic [AW-1:0] wr_addr, rd_addr;

  assign wr_addr     = AW'(slot_addr(32'(wr_buf), 32'(wr_cnt), PKT_BYTES));
  assign rd_addr     = AW'(slot_addr(32'(rd_buf), 32'(rd_cnt), PKT_BYTES));
  assign commit_full = wr_en && is_final(32'(wr_cnt), PKT_BYTES);
  assign commit      = commit_full || zlp_go;
  assign buf_free    = (n_full != NW'(NBUF));
  assign wr_empty    = (wr_cnt == '0);
  assign out_valid   = (n_full != '0) && !nak;
  assign out_empty   = zflag[rd_buf];
  assign out_last    = out_empty || is_final(32'(rd_cnt), PKT_BYTES);
  assign out_data    = out_empty ? 8'h00 : mem[rd_addr];
  assign out_fire    = out_valid && out_ready;
  assign release_buf = out_fire && out_last;

  always_ff @(posedge clk) begin
    if (wr_en && !clr) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_buf <= '0; rd_buf <= '0; wr_cnt <= '0; rd_cnt <= '0;
      n_full <= '0; zflag  <= '0;
    end else if (clr) begin
      wr_buf <= '0; rd_buf <= '0; wr_cnt <= '0; rd_cnt <= '0;
      n_full <= '0; zflag  <= '0;
    end else begin
      if (wr_en) begin
        if (commit_full) begin
          wr_cnt        <= '0;
          zflag[wr_buf] <= 1'b0;
          wr_buf        <= BW'(ring_inc(32'(wr_buf), NBUF));
        end else begin
          wr_cnt <= wr_cnt + 1'b1;
        end
      end else if (drop) begin
        wr_cnt <= '0;
      end else if (zlp_go) begin
        zflag[wr_buf] <= 1'b1;
        wr_buf        <= BW'(ring_inc(32'(wr_buf), NBUF));
      end
      if (out_fire) begin
        if (out_last) begin
          rd_cnt <= '0;
          rd_buf <= BW'(ring_inc(32'(rd_buf), NBUF));
        end else begin
          rd_cnt <= rd_cnt + 1'b1;
        end
      end
      n_full <= n_full + NW'(commit) - NW'(release_buf);
    end
  end

endmodule

// File: rtl/pkt_stream_packer.sv
module pkt_stream_packer
  import psp_pkg::*;
#(
  parameter int PKT_BYTES = 512,
  parameter int NBUF      = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       fifo_rst,
  input  logic       zlp_req,
  input  logic       src_rdy,
  input  logic [7:0] src_data,
  output logic       rd_strobe,
  output logic       cap_done,
  output logic       overflow,
  output logic       nak_all,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_last,
  output logic       out_empty
);

  // named internal events
  logic byte_take, drop, cap_off, ovf_evt;
  logic buf_free, wr_empty, fl_busy, clr, hold, zlp_go;

  // a pending or running flush blocks the start of a new transfer
  assign hold   = fl_busy || fifo_rst;
  assign zlp_go = zlp_req && cap_off && wr_empty && buf_free && !hold;

  psp_capture_fsm u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .src_rdy   (src_rdy),
    .buf_free  (buf_free),
    .hold      (hold),
    .rd_strobe (rd_strobe),
    .byte_take (byte_take),
    .drop      (drop),
    .cap_done  (cap_done),
    .cap_off   (cap_off),
    .ovf_evt   (ovf_evt)
  );

  psp_flush_seq u_flush (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_rst (fifo_rst),
    .cap_done (cap_done),
    .nak      (nak_all),
    .clr      (clr),
    .busy     (fl_busy)
  );

  psp_ring_store #(
    .PKT_BYTES (PKT_BYTES),
    .NBUF      (NBUF)
  ) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (byte_take),
    .wr_data   (src_data),
    .drop      (drop),
    .zlp_go    (zlp_go),
    .clr       (clr),
    .nak       (nak_all),
    .out_ready (out_ready),
    .buf_free  (buf_free),
    .wr_empty  (wr_empty),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_empty (out_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       overflow <= 1'b0;
    else if (clr)     overflow <= 1'b0;
    else if (ovf_evt) overflow <= 1'b1;
  end

endmodule

// File: rtl/psp_checker.sv
module psp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       arm,
  input logic       fifo_rst,
  input logic       src_rdy,
  input logic       rd_strobe,
  input logic       cap_done,
  input logic       overflow,
  input logic       nak_all,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       out_empty
);

  // R9
  nak_blocks_traffic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nak_all |-> (!out_valid && !rd_strobe));

  // R9
  nak_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nak_all) |-> $past(fifo_rst && cap_done));

  // R9
  flush_leaves_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nak_all) |-> !out_valid);

  // R10
  beat_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !fifo_rst) |=>
      (out_valid && $stable(out_data) && $stable(out_last)));

  // R5
  overflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(src_rdy && !rd_strobe && arm));

  // R8
  zlp_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_empty) |-> (out_last && out_data == 8'h00));

  // R6
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !src_rdy) |=> !cap_done);

endmodule

bind pkt_stream_packer psp_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .arm       (arm),
  .fifo_rst  (fifo_rst),
  .src_rdy   (src_rdy),
  .rd_strobe (rd_strobe),
  .cap_done  (cap_done),
  .overflow  (overflow),
  .nak_all   (nak_all),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last),
  .out_empty (out_empty)
);

// File: tb/test_pkt_stream_packer.sv
`timescale 1ns/1ps
module test_pkt_stream_packer;

  localparam int PKT = 8;
  localparam int NB  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0, fifo_rst = 1'b0, zlp_req = 1'b0;
  logic src_rdy = 1'b0;
  logic [7:0] src_data = 8'h00;
  logic out_ready = 1'b0;
  logic rd_strobe, cap_done, overflow, nak_all;
  logic out_valid, out_last, out_empty;
  logic [7:0] out_data;

  always #2 clk = ~clk;

  pkt_stream_packer #(.PKT_BYTES(PKT), .NBUF(NB)) i_pkt_stream_packer (
    .clk(clk), .rst_n(rst_n), .arm(arm), .fifo_rst(fifo_rst), .zlp_req(zlp_req),
    .src_rdy(src_rdy), .src_data(src_data), .rd_strobe(rd_strobe),
    .cap_done(cap_done), .overflow(overflow), .nak_all(nak_all),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_empty(out_empty)
  );

  int checks = 0, errors = 0, cyc = 0;
  int n_push = 0, rx_pkts = 0, rx_zlp = 0, zlp_exp = 0, beat_idx = 0, slow_cnt = 0;
  logic [7:0] val = 8'h00;
  logic [7:0] pend[$];
  logic [7:0] exp_q[$];
  bit src_en = 0, src_slow = 0, rogue = 0;
  int sink_mode = 0; // 0 stalled, 1 always ready, 2 alternate

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // driver: answers strobes and files expected packets (R1, R2)
  always @(negedge clk) begin
    if (src_en && rd_strobe && (!src_slow || slow_cnt == 2)) begin
      slow_cnt = 0;
      src_rdy  <= 1'b1;
      src_data <= val;
      pend.push_back(val);
      val++;
      n_push++;
      if (pend.size() == PKT) begin
        foreach (pend[i]) exp_q.push_back(pend[i]);
        pend.delete();
      end
    end else begin
      if (src_en && rd_strobe) slow_cnt++;
      if (rogue && !rd_strobe) begin
        src_rdy  <= 1'b1;
        src_data <= 8'hEE;
      end else begin
        src_rdy <= 1'b0;
      end
    end
  end

  // monitor: chooses ready and scores every beat that will fire at the next edge
  always @(negedge clk) begin
    case (sink_mode)
      0:       out_ready = 1'b0;
      1:       out_ready = 1'b1;
      default: out_ready = ~out_ready;
    endcase
    if (rst_n && out_valid && out_ready) begin
      if (out_empty) begin
        chk(zlp_exp > 0 && out_last && beat_idx == 0, "R8 zero-length beat", zlp_exp, 1);
        zlp_exp--;
        rx_zlp++;
      end else if (exp_q.size() == 0) begin
        chk(0, "R2 unexpected beat", out_data, -1);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(out_data == e, "R1 byte order", out_data, e);
        chk(out_last == (beat_idx == PKT - 1), "R2 last marker", out_last, beat_idx == PKT - 1);
        if (out_last) begin
          beat_idx = 0;
          rx_pkts++;
        end else begin
          beat_idx++;
        end
      end
    end
  end

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      summary();
    end
  end

  initial begin
    cycles(3);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11
    chk(!rd_strobe, "R11 strobe", rd_strobe, 0);
    chk(!out_valid, "R11 valid", out_valid, 0);
    chk(!nak_all,   "R11 nak", nak_all, 0);
    chk(!overflow,  "R11 overflow", overflow, 0);
    chk(cap_done,   "R11 done", cap_done, 1);

    // Phase A: free-running stream, then stop mid-transfer
    #1 sink_mode = 1; arm = 1'b1; src_en = 1;
    while (n_push < 3 * PKT + 3) @(negedge clk);
    #1 src_en = 0;
    while (!rd_strobe) @(negedge clk);
    #1 arm = 1'b0;
    cycles(3);
    chk(!cap_done && rd_strobe, "R6 busy while outstanding", cap_done, 0);
    chk(rd_strobe, "R7 waits for transfer", rd_strobe, 1);
    #1 src_en = 1;
    cycles(5);
    chk(cap_done && !rd_strobe, "R7 idle after stop", cap_done, 1);
    #1 pend.delete();
    while (rx_pkts < 3) @(negedge clk);
    cycles(20);
    chk(rx_pkts == 3, "R7 partial discarded", rx_pkts, 3);
    chk(!out_valid, "R7 nothing pending", out_valid, 0);

    // Phase B: fill every buffer with output stalled
    #1 sink_mode = 0; src_slow = 1; arm = 1'b1;
    cycles(300);
    chk(n_push == 28 + NB * PKT, "R3 no byte beyond ring", n_push, 28 + NB * PKT);
    chk(!rd_strobe, "R3 strobe stalled", rd_strobe, 0);
    chk(!overflow, "R5 no overflow yet", overflow, 0);
    chk(out_valid && out_data == exp_q[0], "R10 head held", out_data, exp_q[0]);
    #1 rogue = 1;
    @(negedge clk);
    #1 rogue = 0;
    @(negedge clk);
    chk(overflow, "R5 overflow set", overflow, 1);
    chk(n_push == 28 + NB * PKT, "R5 rogue byte not counted", n_push, 28 + NB * PKT);
    #1 sink_mode = 2;
    while (rx_pkts < 3 + NB + 2) @(negedge clk);
    chk(n_push > 28 + NB * PKT, "R4 capture resumed", n_push, 28 + NB * PKT + 1);
    #1 arm = 1'b0;
    cycles(12);
    #1 pend.delete();
    while (exp_q.size() != 0) @(negedge clk);
    cycles(20);
    chk(!out_valid, "R7 stop drains to empty", out_valid, 0);

    // Phase C: zero-length packet
    #1 sink_mode = 1; zlp_exp = 1; zlp_req = 1'b1;
    @(negedge clk);
    #1 zlp_req = 1'b0;
    cycles(10);
    chk(rx_zlp == 1, "R8 zero-length packet seen", rx_zlp, 1);

    // Phase D: flush with data stuck inside
    #1 sink_mode = 0; src_slow = 0; arm = 1'b1;
    cycles(120);
    chk(!rd_strobe && out_valid, "R3 full again", rd_strobe, 0);
    #1 arm = 1'b0;
    cycles(5);
    chk(overflow, "R5 flag sticky", overflow, 1);
    #1 fifo_rst = 1'b1;
    @(negedge clk);
    chk(nak_all && !out_valid, "R9 nak first cycle", nak_all, 1);
    #1 fifo_rst = 1'b0;
    @(negedge clk);
    chk(nak_all && !out_valid, "R9 nak second cycle", nak_all, 1);
    @(negedge clk);
    chk(!nak_all, "R9 nak released", nak_all, 0);
    chk(!out_valid, "R9 buffers cleared", out_valid, 0);
    chk(!overflow, "R5 flush clears flag", overflow, 0);
    #1 exp_q.delete(); pend.delete();

    // Phase E: streaming after flush
    #1 sink_mode = 1; arm = 1'b1;
    begin
      int base;
      base = rx_pkts;
      while (rx_pkts < base + 2) @(negedge clk);
      chk(rx_pkts >= base + 2, "R2 stream after flush", rx_pkts, base + 2);
    end
    #1 arm = 1'b0;
    cycles(30);
    summary();
  end

endmodule